// File: doc/BRIEF.md
# Multiplexed Segment LCD Timing Driver

This block produces the drive levels for the common and segment pins of a segment liquid-crystal display. It does not produce any analog voltage. For every pin it outputs a 3-bit index into a five-level ladder: V1 is full scale, V2 is 2/3, V3 is 1/2, V4 is 1/3 and V5 is ground. An external bias network turns each index into a pin voltage. The block runs from the 32768 Hz auxiliary clock. A programmable prescaler divides this clock to give the phase rate.

A frame has 2 × mux phases, so the phase rate is 2 × mux × frame rate. During the first half of a frame, the phases select the commons one at a time. During the second half, the same sequence repeats with every level mirrored, so the panel sees no net DC. The display memory is supplied as a flat vector with one bit per segment pin for each common. Segment pins are enabled in groups of four. An optional blink function blanks the whole pattern for alternating runs of frames.

Top module: `seg_lcd_drv`

## Requirements
- R1: While `enable` is low, every common and segment output is level code 5 (V5). The prescaler, phase and blink state are cleared, so raising `enable` starts at phase 0 of a visible frame.
- R2: The phase advances once every 2^(`freq_sel`+1) clock cycles and holds its level codes in between.
- R3: `mux_sel` selects the mode: 0 static, 1 two-mux, 2 three-mux, 3 four-mux. With m = `mux_sel`+1, a frame has 2m phases. Phase p selects common p mod m. For p ≥ m, every level code x of a used pin becomes 6−x, which swaps V1 with V5 and V2 with V4 and leaves V3 unchanged.
- R4: In static mode, common 0 uses only V1 and V5. A lit segment takes the opposite level to common 0, and an unlit segment takes the same level. `half_bias` has no effect in this mode.
- R5: With `half_bias` = 0 (one-third bias) in a multiplexed mode, the selected common is V1 and the unselected commons are V4 in the first half-frame. A lit segment is V5 and an unlit segment is V3.
- R6: With `half_bias` = 1 (one-half bias) in a multiplexed mode, the unselected commons are V3. Segment levels are the same as in R5.
- R7: A common whose index is not below m (unused in the current mode) is always V5.
- R8: Bit g of `grp_en` enables segment pins 4g to 4g+3. A pin in a disabled group is always V5.
- R9: The segment state of pin s for common c is bit c×NUM_SEG+s of `seg_data`. A 1 means lit.
- R10: With `blink_en` = 1, the pattern is shown for BLINK_FRAMES frames, then every segment is unlit for BLINK_FRAMES frames, and so on. With `blink_en` = 0, the pattern is always shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz auxiliary clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| mux_sel | input | 2 | Mode: 0 static, 1/2/3 for 2/3/4-mux |
| half_bias | input | 1 | 1 selects one-half bias, 0 selects one-third bias |
| freq_sel | input | 3 | Prescaler select; the divide ratio is 2^(freq_sel+1) |
| blink_en | input | 1 | Blink enable |
| grp_en | input | 8 | Segment group enables, four pins per bit |
| seg_data | input | 128 | Display memory, bit c×32+s |
| com_lvl | output | 12 | Common level codes, 3 bits per common, common 0 in the low bits |
| seg_lvl | output | 96 | Segment level codes, 3 bits per pin, pin 0 in the low bits |

## Verification
A wrong phase counter or prescaler shows up as the selected common, the mirrored half or the lit pattern appearing in the wrong cycle. Every pin is compared against an independent model on every clock, so such an error is caught within one phase period. A wrong bias or mode decode produces a wrong level code on the commons or segments in the first phase where that code is used. A blink counter that is off by one frame inverts the blanking exactly at a frame boundary, and the tests run long enough to cross that boundary.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;
    localparam logic [2:0] LV1 = 3'd1;
    localparam logic [2:0] LV3 = 3'd3;
    localparam logic [2:0] LV4 = 3'd4;
    localparam logic [2:0] LV5 = 3'd5;

    // Mirror a level about the mid-rail for the second half of a frame.
    function automatic logic [2:0] mirror_lvl(input logic [2:0] v, input logic inv);
        return inv ? (3'd6 - v) : v;
    endfunction
endpackage

// File: rtl/seg_lcd_timebase.sv
module seg_lcd_timebase #(
    parameter int MAX_COM      = 4,
    parameter int FS_W         = 3,
    parameter int BLINK_FRAMES = 2,
    localparam int MS_W  = $clog2(MAX_COM),
    localparam int PH_W  = $clog2(2 * MAX_COM),
    localparam int DIV_W = 2 ** FS_W,
    localparam int BF_W  = $clog2(BLINK_FRAMES) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [MS_W-1:0] mux_sel,
    input  logic [FS_W-1:0] freq_sel,
    input  logic            blink_en,
    output logic [PH_W-1:0] phase,
    output logic [MS_W-1:0] com_idx,
    output logic            invert,
    output logic            blank
);
    typedef struct packed {
        logic [DIV_W-1:0] presc;
        logic [PH_W-1:0]  phase;
        logic [BF_W-1:0]  fcnt;
        logic             blank;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [DIV_W:0]  lim;
    logic [PH_W:0]   mux_n, last_ph, ph_ext;
    logic            wrap;

    assign lim     = ((DIV_W+1)'(2) << freq_sel) - 1'b1;
    assign mux_n   = (PH_W+1)'(mux_sel) + 1'b1;
    assign last_ph = (mux_n << 1) - 1'b1;
    assign ph_ext  = {1'b0, st_q.phase};

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else begin
            if ({1'b0, st_q.presc} >= lim) begin
                st_d.presc = '0;
                if (ph_ext >= last_ph) begin
                    st_d.phase = '0;
                    wrap       = 1'b1;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
            if (!blink_en) begin
                st_d.fcnt  = '0;
                st_d.blank = 1'b0;
            end else if (wrap) begin
                if (st_q.fcnt >= BF_W'(BLINK_FRAMES - 1)) begin
                    st_d.fcnt  = '0;
                    st_d.blank = ~st_q.blank;
                end else begin
                    st_d.fcnt = st_q.fcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase   = st_q.phase;
    assign invert  = ph_ext >= mux_n;
    assign com_idx = MS_W'(invert ? (ph_ext - mux_n) : ph_ext);
    assign blank   = st_q.blank;
endmodule

// File: rtl/seg_lcd_levels.sv
module seg_lcd_levels
    import seg_lcd_pkg::*;
#(
    parameter int MAX_COM = 4,
    parameter int NUM_SEG = 32,
    localparam int MS_W    = $clog2(MAX_COM),
    localparam int NUM_GRP = NUM_SEG / 4
) (
    input  logic                       enable,
    input  logic [MS_W-1:0]            mux_sel,
    input  logic                       half_bias,
    input  logic [MS_W-1:0]            com_idx,
    input  logic                       invert,
    input  logic                       blank,
    input  logic [NUM_GRP-1:0]         grp_en,
    input  logic [MAX_COM*NUM_SEG-1:0] seg_data,
    output logic [MAX_COM*3-1:0]       com_lvl,
    output logic [NUM_SEG*3-1:0]       seg_lvl
);
    logic static_mode;
    assign static_mode = (mux_sel == '0);

    for (genvar c = 0; c < MAX_COM; c++) begin : g_com
        localparam logic [MS_W:0] CI = (MS_W+1)'(c);
        logic [2:0] base;
        always_comb begin
            if (com_idx == CI[MS_W-1:0]) base = LV1;
            else if (half_bias)          base = LV3;
            else                         base = LV4;
            if (!enable || (CI > {1'b0, mux_sel}))
                com_lvl[c*3 +: 3] = LV5;
            else
                com_lvl[c*3 +: 3] = mirror_lvl(base, invert);
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [MAX_COM-1:0] col;
        logic [2:0]         base;
        logic               lit;
        for (genvar c = 0; c < MAX_COM; c++) begin : g_col
            assign col[c] = seg_data[c*NUM_SEG + s];
        end
        always_comb begin
            lit = col[com_idx] & ~blank;
            if (lit)              base = LV5;
            else if (static_mode) base = LV1;
            else                  base = LV3;
            if (!enable || !grp_en[s/4])
                seg_lvl[s*3 +: 3] = LV5;
            else
                seg_lvl[s*3 +: 3] = mirror_lvl(base, invert);
        end
    end
endmodule

// File: rtl/seg_lcd_drv.sv
module seg_lcd_drv #(
    parameter int MAX_COM      = 4,
    parameter int NUM_SEG      = 32,
    parameter int FS_W         = 3,
    parameter int BLINK_FRAMES = 2,
    localparam int MS_W    = $clog2(MAX_COM),
    localparam int PH_W    = $clog2(2 * MAX_COM),
    localparam int NUM_GRP = NUM_SEG / 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [MS_W-1:0]            mux_sel,
    input  logic                       half_bias,
    input  logic [FS_W-1:0]            freq_sel,
    input  logic                       blink_en,
    input  logic [NUM_GRP-1:0]         grp_en,
    input  logic [MAX_COM*NUM_SEG-1:0] seg_data,
    output logic [MAX_COM*3-1:0]       com_lvl,
    output logic [NUM_SEG*3-1:0]       seg_lvl
);
    logic [PH_W-1:0] phase;
    logic [MS_W-1:0] com_idx;
    logic            invert;
    logic            blank;

    seg_lcd_timebase #(
        .MAX_COM(MAX_COM), .FS_W(FS_W), .BLINK_FRAMES(BLINK_FRAMES)
    ) i_timebase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mux_sel(mux_sel),
        .freq_sel(freq_sel), .blink_en(blink_en), .phase(phase),
        .com_idx(com_idx), .invert(invert), .blank(blank)
    );

    seg_lcd_levels #(
        .MAX_COM(MAX_COM), .NUM_SEG(NUM_SEG)
    ) i_levels (
        .enable(enable), .mux_sel(mux_sel), .half_bias(half_bias),
        .com_idx(com_idx), .invert(invert), .blank(blank), .grp_en(grp_en),
        .seg_data(seg_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );
endmodule

// File: rtl/seg_lcd_chk.sv
module seg_lcd_chk #(
    parameter int MAX_COM = 4,
    parameter int NUM_SEG = 32,
    parameter int MS_W    = 2,
    parameter int PH_W    = 3,
    parameter int NUM_GRP = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic [MS_W-1:0]      mux_sel,
    input logic                 blink_en,
    input logic [NUM_GRP-1:0]   grp_en,
    input logic [PH_W-1:0]      phase,
    input logic                 blank,
    input logic [MAX_COM*3-1:0] com_lvl,
    input logic [NUM_SEG*3-1:0] seg_lvl
);
    AST_DISABLED_ALL_V5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (com_lvl == {MAX_COM{3'd5}} && seg_lvl == {NUM_SEG{3'd5}})); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && enable && phase != $past(phase))
            |-> (phase == $past(phase) + 1'b1 || phase == '0)); // R3

    AST_STATIC_EXTREMES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mux_sel == '0) |-> (com_lvl[2:0] == 3'd1 || com_lvl[2:0] == 3'd5)); // R4

    AST_UNUSED_COM_V5: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == '0) |-> (com_lvl[5:3] == 3'd5)); // R7

    AST_GROUP_OFF_V5: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en[0] |-> (seg_lvl[11:0] == {4{3'd5}})); // R8

    AST_NO_BLINK_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> !blank); // R10
endmodule

bind seg_lcd_drv seg_lcd_chk #(
    .MAX_COM(MAX_COM), .NUM_SEG(NUM_SEG), .MS_W(MS_W), .PH_W(PH_W), .NUM_GRP(NUM_GRP)
) i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mux_sel(mux_sel),
    .blink_en(blink_en), .grp_en(grp_en), .phase(phase), .blank(blank),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/test_seg_lcd_drv.sv
module test_seg_lcd_drv;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG  = 32;
    localparam int NCOM  = 4;
    localparam int BLINK = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 enable = 1'b0;
    logic [1:0]           mux_sel = '0;
    logic                 half_bias = 1'b0;
    logic [2:0]           freq_sel = '0;
    logic                 blink_en = 1'b0;
    logic [NSEG/4-1:0]    grp_en = '1;
    logic [NCOM*NSEG-1:0] seg_data = '0;
    logic [NCOM*3-1:0]    com_lvl;
    logic [NSEG*3-1:0]    seg_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_lcd_drv i_seg_lcd_drv (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mux_sel(mux_sel),
        .half_bias(half_bias), .freq_sel(freq_sel), .blink_en(blink_en),
        .grp_en(grp_en), .seg_data(seg_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [2:0] mir(logic [2:0] v, bit inv);
        return inv ? 3'd6 - v : v;
    endfunction

    task automatic compare(string req, int ph, int frame, bit en);
        logic [NCOM*3-1:0] ec;
        logic [NSEG*3-1:0] es;
        int  m  = int'(mux_sel) + 1;
        bit  inv = ph >= m;
        int  ci = ph % m;
        bit  blk = blink_en && (((frame / BLINK) % 2) == 1);
        for (int c = 0; c < NCOM; c++) begin
            logic [2:0] b;
            b = (c == ci) ? 3'd1 : (half_bias ? 3'd3 : 3'd4);
            ec[c*3 +: 3] = (!en || c >= m) ? 3'd5 : mir(b, inv);
        end
        for (int s = 0; s < NSEG; s++) begin
            logic [2:0] b;
            bit lit = seg_data[ci*NSEG + s] && !blk;
            b = lit ? 3'd5 : ((m == 1) ? 3'd1 : 3'd3);
            es[s*3 +: 3] = (!en || !grp_en[s/4]) ? 3'd5 : mir(b, inv);
        end
        n_chk++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            n_fail++;
            $display("FAIL %s phase %0d: com %h seg %h, expected com %h seg %h",
                     req, ph, com_lvl, seg_lvl, ec, es);
        end
    endtask

    // Disable, reconfigure, enable and compare on every clock for nclk cycles.
    task automatic run_case(string req, logic [1:0] mx, logic hb, logic [2:0] fs,
                            logic [NCOM*NSEG-1:0] dat, logic [7:0] ge, logic bl, int nclk);
        int div = 2 << fs;
        int m2  = 2 * (int'(mx) + 1);
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        #1 compare("R1", 0, 0, 1'b0);
        mux_sel = mx; half_bias = hb; freq_sel = fs; seg_data = dat;
        grp_en = ge; blink_en = bl; enable = 1'b1;
        for (int t = 0; t < nclk; t++) begin
            int k = t / div;
            #1 compare(req, k % m2, k / m2, 1'b1);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        #1 compare("R1", 0, 0, 1'b0);
    endtask

    task automatic t_static();      // R4 R9
        run_case("R4", 2'd0, 1'b1, 3'd0, {96'h0, 32'hF0F0_1234}, 8'hFF, 1'b0, 40);
    endtask

    task automatic t_two_mux_half(); // R6 R7
        run_case("R6", 2'd1, 1'b1, 3'd0, {64'h0, 32'hAAAA_5555, 32'h0F0F_C3C3}, 8'hFF, 1'b0, 40);
    endtask

    task automatic t_three_mux_third(); // R5 R3 R9
        run_case("R5", 2'd2, 1'b0, 3'd0, {32'h0, 32'h8001_7FFE, 32'h1357_9BDF, 32'hDEAD_BEEF}, 8'hFF, 1'b0, 60);
    endtask

    task automatic t_four_mux_groups(); // R8 R3
        run_case("R8", 2'd3, 1'b0, 3'd0, {32'hFFFF_FFFF, 32'h1234_5678, 32'hCAFE_F00D, 32'h0000_FFFF}, 8'hA5, 1'b0, 64);
    endtask

    task automatic t_prescale();    // R2
        run_case("R2", 2'd1, 1'b0, 3'd2, {64'h0, 32'h0000_FFFF, 32'hFFFF_0000}, 8'hFF, 1'b0, 120);
        run_case("R2", 2'd3, 1'b1, 3'd4, {4{32'h6666_9999}}, 8'h3C, 1'b0, 300);
    endtask

    task automatic t_blink();       // R10
        run_case("R10", 2'd1, 1'b0, 3'd0, {64'h0, 32'h5A5A_A5A5, 32'hFFFF_FFFF}, 8'hFF, 1'b1, 80);
    endtask

    task automatic t_disable_midrun(); // R1
        run_case("R1", 2'd3, 1'b0, 3'd0, {4{32'h0F0F_0F0F}}, 8'hFF, 1'b1, 13);
        enable = 1'b0;
        #1 compare("R1", 0, 0, 1'b0);
        @(negedge clk);
        enable = 1'b1;
        #1 compare("R1", 0, 0, 1'b1);
        @(negedge clk);
        #1 compare("R1", 0, 0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static();
        t_two_mux_half();
        t_three_mux_third();
        t_four_mux_groups();
        t_prescale();
        t_blink();
        t_disable_midrun();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule